// File: doc/BRIEF.md
# Shifted Register Operand Fetch

This block forms the second operand of a 32-bit data-processing datapath and the carry that the shifter produces with it. Given the decoded shift fields of an instruction, it reads the operand register Rm through one register-file read port and, when the shift count is taken from a register, reads the count register Rs through a second port. It then feeds the operand through a barrel shifter that applies one of four shift kinds. Register 15 is not a storage location here. It stands for the program counter, and the word it yields depends on which slot it occupies and on how the shift count is supplied.

A request is presented for one cycle with `req_valid`. The shifted operand and the carry are registered and appear one cycle later, qualified by `out_valid`. The PC arrives as a word index, with bits 25:2 of the byte address in `pc_word`, and the status bits arrive on their own inputs. Register-specified shift counts can be switched off at run time with `reg_shift_en`, or removed from the hardware with the `ALLOW_REG_SHIFT` parameter. The ALU, rotated-immediate operands and memory access belong to other blocks.

Top module: `shifted_operand_fetch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `out_valid`=0, `out_value`=0 and `out_carry`=0, whatever the other inputs are.
- R2: A request taken with `req_valid`=1 at edge k gives its result on `out_value` and `out_carry` with `out_valid`=1 after edge k. With no request, `out_valid` is 0 after the edge and `out_value` and `out_carry` keep their previous values.
- R3: Shift kinds are coded 00 left logical, 01 right logical, 10 right arithmetic and 11 rotate right. For an immediate count n of 1 to 31 the result is the operand shifted by n. The carry is the last bit shifted out, which for rotate right is result bit 31.
- R4: An immediate count of 0 has a special meaning for each kind. Left logical passes the operand through with the carry unchanged. Right logical gives 0 with carry = operand bit 31. Right arithmetic gives 32 copies of bit 31 with carry = bit 31. Rotate right is a 33-bit rotate through the carry, giving {carry_in, operand[31:1]} with carry = operand bit 0.
- R5: A register-specified count uses only bits 7:0 of Rs. A count of 0 leaves the operand and the carry unchanged.
- R6: Register counts of 32 or more saturate as follows. Left logical by 32 gives 0 with carry = bit 0. Right logical by 32 gives 0 with carry = bit 31. Either logical shift by more than 32 gives 0 with carry 0. Right arithmetic gives sign fill with carry = bit 31. Rotate by a nonzero multiple of 32 leaves the operand unchanged with carry = bit 31. Any other rotate count rotates by the count modulo 32.
- R7: When Rm is 15, the operand is {N,Z,C,V in 31:28, interrupt masks in 27:26, advanced PC word in 25:2, mode in 1:0}. The PC is advanced by 8 bytes when the count is immediate and by 12 bytes when the count comes from a register.
- R8: When Rs is 15, the count register reads as the PC advanced by 8 bytes, with bits 31:26 and 1:0 forced to zero, so the mode bits never reach the count.
- R9: With `reg_shift_en`=0, `shift_by_reg` is ignored. The immediate count is used, and an Rm of 15 takes the PC advanced by 8 bytes.
- R10: `rf_rm_addr` and `rf_rs_addr` follow `rm_idx` and `rs_idx` combinationally. When an index is 15, the register-file data for that slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_shift_en | input | 1 | Allows register-specified shift counts |
| req_valid | input | 1 | Request strobe, one cycle per operand |
| rm_idx | input | 4 | Operand register index |
| rs_idx | input | 4 | Shift-count register index |
| shift_by_reg | input | 1 | Count comes from Rs instead of the immediate field |
| shift_kind | input | 2 | Shift kind code |
| shift_imm | input | 5 | Immediate shift count |
| carry_in | input | 1 | Current carry flag |
| pc_word | input | 24 | PC byte address bits 25:2 |
| psr_nzcv | input | 4 | Condition flags N,Z,C,V |
| psr_masks | input | 2 | Interrupt mask bits |
| psr_mode | input | 2 | Processor mode |
| rf_rm_addr | output | 4 | Register-file read address, operand port |
| rf_rm_data | input | 32 | Register-file read data, operand port |
| rf_rs_addr | output | 4 | Register-file read address, count port |
| rf_rs_byte | input | 8 | Low byte of the count register |
| out_valid | output | 1 | Result valid |
| out_value | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
The read addresses are combinational, so the bench checks them 1 ns after driving the indices, in the same cycle. The operand and carry pass through exactly one register. The bench drives each request at a falling edge, lets one rising edge capture it, and samples `out_value`, `out_carry` and `out_valid` at the next falling edge. The hold behaviour is checked two falling edges later, with no request in between.

// File: rtl/opfetch_pkg.sv
// Package: opfetch_pkg
// Widths, shift-kind codes and the control record shared by the operand
// fetch block. Assumes a 32-bit word and a 16-entry register file.
package opfetch_pkg;
    localparam int WORD_W    = 32;
    localparam int REG_IDX_W = 4;
    localparam int IMM_AMT_W = 5;
    localparam int REG_AMT_W = 8;
    localparam int PCW_W     = 24;
    localparam int NZCV_W    = 4;
    localparam int MASK_W    = 2;
    localparam int MODE_W    = 2;

    localparam logic [REG_IDX_W-1:0] PC_REG_IDX = REG_IDX_W'(15);
    // PC advance in words: 8 bytes near, 12 bytes far
    localparam logic [PCW_W-1:0] PC_NEAR_WORDS = PCW_W'(2);
    localparam logic [PCW_W-1:0] PC_FAR_WORDS  = PCW_W'(3);

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [NZCV_W-1:0] nzcv;
        logic [MASK_W-1:0] masks;
        logic [MODE_W-1:0] mode;
    } psr_bits_t;

    typedef struct packed {
        shift_kind_e          kind;
        logic [REG_AMT_W-1:0] amount;
        logic                 rrx;
    } shift_ctl_t;
endpackage

// File: rtl/opfetch_operand_sel.sv
// Module: opfetch_operand_sel
// Resolves the Rm operand word and the Rs count byte. Index 15 is replaced
// by PC-derived values: Rm gets the PC merged with status bits (PC + 8 or
// + 12), and Rs gets PC + 8 with the status bits zeroed.
// Assumes the register file returns data in the same cycle as the address.
module opfetch_operand_sel
    import opfetch_pkg::*;
(
    input  logic [REG_IDX_W-1:0] rm_idx,
    input  logic [REG_IDX_W-1:0] rs_idx,
    input  logic [WORD_W-1:0]    rf_rm_data,
    input  logic [REG_AMT_W-1:0] rf_rs_byte,
    input  logic [PCW_W-1:0]     pc_word,
    input  psr_bits_t            psr,
    input  logic                 use_reg_count,
    output logic [WORD_W-1:0]    rm_value,
    output logic [REG_AMT_W-1:0] rs_byte
);
    localparam int LOW_PC_BITS = REG_AMT_W - MODE_W;

    logic [PCW_W-1:0] pc_near;
    logic [PCW_W-1:0] pc_far;

    // Advanced PC words for the two pipeline positions
    always_comb begin
        pc_near = pc_word + PC_NEAR_WORDS;
        pc_far  = pc_word + PC_FAR_WORDS;
    end

    // Operand select: PC with status for index 15, register data otherwise
    always_comb begin
        if (rm_idx == PC_REG_IDX) begin
            rm_value = {psr.nzcv, psr.masks,
                        (use_reg_count ? pc_far : pc_near), psr.mode};
        end else begin
            rm_value = rf_rm_data;
        end
    end

    // Count byte select: low byte of zero-status PC word for index 15
    always_comb begin
        if (rs_idx == PC_REG_IDX) begin
            rs_byte = {pc_near[LOW_PC_BITS-1:0], {MODE_W{1'b0}}};
        end else begin
            rs_byte = rf_rs_byte;
        end
    end
endmodule

// File: rtl/opfetch_amount_sel.sv
// Module: opfetch_amount_sel
// Chooses the effective shift count and translates the immediate zero-count
// encodings (right shifts by 32, rotate-through-carry). When ALLOW_REG_SHIFT
// is 0 the register-count path is not built at all.
// Assumes rs_byte is already resolved for index 15.
module opfetch_amount_sel
    import opfetch_pkg::*;
#(
    parameter bit ALLOW_REG_SHIFT = 1'b1
) (
    input  logic                 shift_by_reg,
    input  logic                 reg_shift_en,
    input  logic [1:0]           shift_kind,
    input  logic [IMM_AMT_W-1:0] shift_imm,
    input  logic [REG_AMT_W-1:0] rs_byte,
    output logic                 use_reg_count,
    output shift_ctl_t           ctl
);
    localparam logic [REG_AMT_W-1:0] FULL_WORD = REG_AMT_W'(WORD_W);

    shift_kind_e kind;
    shift_ctl_t  imm_ctl;

    // Cast the raw code to the shift-kind type
    always_comb kind = shift_kind_e'(shift_kind);

    // Immediate count decode, zero count takes a per-kind meaning
    always_comb begin
        imm_ctl.kind   = kind;
        imm_ctl.amount = REG_AMT_W'(shift_imm);
        imm_ctl.rrx    = 1'b0;
        if (shift_imm == '0) begin
            unique case (kind)
                SH_LSL:         imm_ctl.amount = '0;
                SH_LSR, SH_ASR: imm_ctl.amount = FULL_WORD;
                SH_ROR:         imm_ctl.rrx    = 1'b1;
                default:        imm_ctl.amount = '0;
            endcase
        end
    end

    generate
        if (ALLOW_REG_SHIFT) begin : g_reg_count
            // Register count wins only when both flag and enable are set
            always_comb begin
                use_reg_count = shift_by_reg & reg_shift_en;
                if (use_reg_count) begin
                    ctl.kind   = kind;
                    ctl.amount = rs_byte;
                    ctl.rrx    = 1'b0;
                end else begin
                    ctl = imm_ctl;
                end
            end
        end else begin : g_imm_only
            // Register counts compiled out: immediate count always used
            always_comb begin
                use_reg_count = 1'b0;
                ctl           = imm_ctl;
            end
        end
    endgenerate
endmodule

// File: rtl/opfetch_shifter.sv
// Module: opfetch_shifter
// Barrel shifter with carry-out for the four shift kinds. Takes an 8-bit
// count with saturation above 32 and a separate rotate-through-carry flag.
// A zero count without rrx passes value and carry through.
module opfetch_shifter
    import opfetch_pkg::*;
(
    input  logic [WORD_W-1:0] value,
    input  shift_ctl_t        ctl,
    input  logic              carry_in,
    output logic [WORD_W-1:0] result,
    output logic              carry_out
);
    localparam int EXT_W = WORD_W + 1;
    localparam int CNT_W = $clog2(EXT_W) + 1;
    localparam int ROT_W = $clog2(WORD_W);
    localparam logic [REG_AMT_W-1:0] LOG_CAP = REG_AMT_W'(EXT_W);
    localparam logic [REG_AMT_W-1:0] ARI_CAP = REG_AMT_W'(WORD_W);

    logic [CNT_W-1:0]  n_log;
    logic [CNT_W-1:0]  n_ari;
    logic [ROT_W-1:0]  n_rot;
    logic [EXT_W-1:0]  lsl_w;
    logic [EXT_W-1:0]  lsr_w;
    logic [EXT_W-1:0]  asr_w;
    logic [WORD_W-1:0] ror_w;

    // Saturate counts: logical to 33, arithmetic to 32, rotate modulo 32
    always_comb begin
        n_log = (ctl.amount > LOG_CAP) ? CNT_W'(EXT_W)  : CNT_W'(ctl.amount);
        n_ari = (ctl.amount > ARI_CAP) ? CNT_W'(WORD_W) : CNT_W'(ctl.amount);
        n_rot = ctl.amount[ROT_W-1:0];
    end

    // Extended shifts keep the last bit out in the extra position
    always_comb begin
        lsl_w = {1'b0, value} << n_log;
        lsr_w = {value, 1'b0} >> n_log;
        asr_w = EXT_W'($signed({value, 1'b0}) >>> n_ari);
        ror_w = (value >> n_rot) | (value << (CNT_W'(WORD_W) - CNT_W'(n_rot)));
    end

    // Select by kind; zero count passes through, rrx rotates via carry
    always_comb begin
        result    = value;
        carry_out = carry_in;
        if (ctl.rrx) begin
            result    = {carry_in, value[WORD_W-1:1]};
            carry_out = value[0];
        end else if (ctl.amount != '0) begin
            unique case (ctl.kind)
                SH_LSL: begin
                    result    = lsl_w[WORD_W-1:0];
                    carry_out = lsl_w[WORD_W];
                end
                SH_LSR: begin
                    result    = lsr_w[EXT_W-1:1];
                    carry_out = lsr_w[0];
                end
                SH_ASR: begin
                    result    = asr_w[EXT_W-1:1];
                    carry_out = asr_w[0];
                end
                SH_ROR: begin
                    result    = ror_w;
                    carry_out = ror_w[WORD_W-1];
                end
                default: begin
                    result    = value;
                    carry_out = carry_in;
                end
            endcase
        end
    end
endmodule

// File: rtl/shifted_operand_fetch.sv
// Module: shifted_operand_fetch
// Top of the operand fetch: drives the register-file read addresses,
// resolves PC reads, picks the shift count, shifts, and registers the
// operand and carry one cycle after the request.
// Assumes a combinational register-file read and a one-cycle request strobe.
module shifted_operand_fetch
    import opfetch_pkg::*;
#(
    parameter bit ALLOW_REG_SHIFT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_shift_en,
    input  logic                 req_valid,
    input  logic [3:0]           rm_idx,
    input  logic [3:0]           rs_idx,
    input  logic                 shift_by_reg,
    input  logic [1:0]           shift_kind,
    input  logic [4:0]           shift_imm,
    input  logic                 carry_in,
    input  logic [23:0]          pc_word,
    input  logic [3:0]           psr_nzcv,
    input  logic [1:0]           psr_masks,
    input  logic [1:0]           psr_mode,
    output logic [3:0]           rf_rm_addr,
    input  logic [31:0]          rf_rm_data,
    output logic [3:0]           rf_rs_addr,
    input  logic [7:0]           rf_rs_byte,
    output logic                 out_valid,
    output logic [31:0]          out_value,
    output logic                 out_carry
);
    psr_bits_t            psr;
    logic                 use_reg_count;
    logic [WORD_W-1:0]    rm_value;
    logic [REG_AMT_W-1:0] rs_byte;
    shift_ctl_t           ctl;
    logic [WORD_W-1:0]    sh_result;
    logic                 sh_carry;

    // Register-file addresses come straight from the decoded indices
    always_comb begin
        rf_rm_addr = rm_idx;
        rf_rs_addr = rs_idx;
    end

    // Bundle the status inputs
    always_comb psr = '{nzcv: psr_nzcv, masks: psr_masks, mode: psr_mode};

    opfetch_operand_sel u_operand_sel (
        .rm_idx        (rm_idx),
        .rs_idx        (rs_idx),
        .rf_rm_data    (rf_rm_data),
        .rf_rs_byte    (rf_rs_byte),
        .pc_word       (pc_word),
        .psr           (psr),
        .use_reg_count (use_reg_count),
        .rm_value      (rm_value),
        .rs_byte       (rs_byte)
    );

    opfetch_amount_sel #(
        .ALLOW_REG_SHIFT (ALLOW_REG_SHIFT)
    ) u_amount_sel (
        .shift_by_reg  (shift_by_reg),
        .reg_shift_en  (reg_shift_en),
        .shift_kind    (shift_kind),
        .shift_imm     (shift_imm),
        .rs_byte       (rs_byte),
        .use_reg_count (use_reg_count),
        .ctl           (ctl)
    );

    opfetch_shifter u_shifter (
        .value     (rm_value),
        .ctl       (ctl),
        .carry_in  (carry_in),
        .result    (sh_result),
        .carry_out (sh_carry)
    );

    // Output register: capture on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_carry <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_value <= sh_result;
                out_carry <= sh_carry;
            end
        end
    end
endmodule

// File: rtl/shifted_operand_fetch_chk.sv
// Module: shifted_operand_fetch_chk
// Port-level properties of the operand fetch, bound into the top module.
module shifted_operand_fetch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_shift_en,
    input logic        req_valid,
    input logic [3:0]  rm_idx,
    input logic [3:0]  rs_idx,
    input logic        shift_by_reg,
    input logic [1:0]  shift_kind,
    input logic [4:0]  shift_imm,
    input logic        carry_in,
    input logic [3:0]  psr_nzcv,
    input logic [1:0]  psr_masks,
    input logic [1:0]  psr_mode,
    input logic [31:0] rf_rm_data,
    input logic [7:0]  rf_rs_byte,
    input logic        out_valid,
    input logic [31:0] out_value,
    input logic        out_carry
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_value == 32'd0 && !out_carry)); // R1

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_value) && $stable(out_carry))); // R2

    AST_IMM_ZERO_LSL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !shift_by_reg && shift_kind == 2'b00 && shift_imm == 5'd0 && rm_idx != 4'd15)
        |=> (out_value == $past(rf_rm_data) && out_carry == $past(carry_in))); // R4

    AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && shift_by_reg && reg_shift_en && rs_idx != 4'd15 && rf_rs_byte == 8'd0 && rm_idx != 4'd15)
        |=> (out_value == $past(rf_rm_data) && out_carry == $past(carry_in))); // R5

    AST_PC_OPERAND_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rm_idx == 4'd15 && !shift_by_reg && shift_kind == 2'b00 && shift_imm == 5'd0)
        |=> (out_value[31:26] == $past({psr_nzcv, psr_masks}) && out_value[1:0] == $past(psr_mode))); // R7

    AST_DISABLED_LSR32_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !reg_shift_en && shift_kind == 2'b01 && shift_imm == 5'd0)
        |=> (out_value == 32'd0)); // R9
endmodule

bind shifted_operand_fetch shifted_operand_fetch_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_shift_en (reg_shift_en),
    .req_valid    (req_valid),
    .rm_idx       (rm_idx),
    .rs_idx       (rs_idx),
    .shift_by_reg (shift_by_reg),
    .shift_kind   (shift_kind),
    .shift_imm    (shift_imm),
    .carry_in     (carry_in),
    .psr_nzcv     (psr_nzcv),
    .psr_masks    (psr_masks),
    .psr_mode     (psr_mode),
    .rf_rm_data   (rf_rm_data),
    .rf_rs_byte   (rf_rs_byte),
    .out_valid    (out_valid),
    .out_value    (out_value),
    .out_carry    (out_carry)
);

// File: tb/shifted_operand_fetch_test.sv
// Directed bench for shifted_operand_fetch: one task per scenario.
module shifted_operand_fetch_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_shift_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  rm_idx = '0;
    logic [3:0]  rs_idx = '0;
    logic        shift_by_reg = 1'b0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_imm = '0;
    logic        carry_in = 1'b0;
    logic [23:0] pc_word = '0;
    logic [3:0]  psr_nzcv = '0;
    logic [1:0]  psr_masks = '0;
    logic [1:0]  psr_mode = '0;
    logic [3:0]  rf_rm_addr;
    logic [31:0] rf_rm_data;
    logic [3:0]  rf_rs_addr;
    logic [7:0]  rf_rs_byte;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_carry;

    logic [31:0] regs [16];
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register-file model with same-cycle read
    always_comb begin
        rf_rm_data = regs[rf_rm_addr];
        rf_rs_byte = regs[rf_rs_addr][7:0];
    end

    shifted_operand_fetch uut (
        .clk (clk), .rst_n (rst_n), .reg_shift_en (reg_shift_en),
        .req_valid (req_valid), .rm_idx (rm_idx), .rs_idx (rs_idx),
        .shift_by_reg (shift_by_reg), .shift_kind (shift_kind),
        .shift_imm (shift_imm), .carry_in (carry_in), .pc_word (pc_word),
        .psr_nzcv (psr_nzcv), .psr_masks (psr_masks), .psr_mode (psr_mode),
        .rf_rm_addr (rf_rm_addr), .rf_rm_data (rf_rm_data),
        .rf_rs_addr (rf_rs_addr), .rf_rs_byte (rf_rs_byte),
        .out_valid (out_valid), .out_value (out_value), .out_carry (out_carry)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit-serial reference: {carry, result} after n single steps
    function automatic logic [32:0] ref_shift(input logic [1:0] k, input int n,
                                              input logic [31:0] v, input logic c);
        logic [31:0] r = v;
        logic co = c;
        for (int i = 0; i < n; i++) begin
            case (k)
                2'b00: begin co = r[31]; r = r << 1; end
                2'b01: begin co = r[0];  r = r >> 1; end
                2'b10: begin co = r[0];  r = {r[31], r[31:1]}; end
                default: begin co = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
        return {co, r};
    endfunction

    // Expected result for an immediate count, zero-count meanings per R4
    function automatic logic [32:0] ref_imm(input logic [1:0] k, input int n,
                                            input logic [31:0] v, input logic c);
        if (n != 0)     return ref_shift(k, n, v, c);
        if (k == 2'b00) return {c, v};
        if (k == 2'b11) return {v[0], c, v[31:1]};
        return ref_shift(k, 32, v, c);
    endfunction

    // Issue one request, sample one edge later at the falling edge
    task automatic issue(input string req, input logic [3:0] rm, input logic [3:0] rs,
                         input logic sbr, input logic [1:0] k, input logic [4:0] imm,
                         input logic cin, input logic [32:0] exp);
        @(negedge clk);
        rm_idx = rm; rs_idx = rs; shift_by_reg = sbr; shift_kind = k;
        shift_imm = imm; carry_in = cin; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " value"}, out_value, exp[31:0]);
        check({req, " carry"}, 32'(out_carry), 32'(exp[32]));
    endtask

    task automatic t_reset;
        @(negedge clk);
        req_valid = 1'b1; rm_idx = 4'd1;
        @(negedge clk);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 value in reset", out_value, 32'd0);
        check("R1 carry in reset", 32'(out_carry), 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_addresses;
        @(negedge clk);
        rm_idx = 4'd7; rs_idx = 4'd9;
        #1;
        check("R10 rm address", 32'(rf_rm_addr), 32'd7);
        check("R10 rs address", 32'(rf_rs_addr), 32'd9);
    endtask

    task automatic t_imm_shifts;
        int amts [3] = '{1, 4, 31};
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 3; a++) begin
                issue("R3 imm shift", 4'd1, 4'd0, 1'b0, 2'(k), 5'(amts[a]), 1'b0,
                      ref_shift(2'(k), amts[a], regs[1], 1'b0));
                issue("R3 imm shift alt", 4'd2, 4'd0, 1'b0, 2'(k), 5'(amts[a]), 1'b1,
                      ref_shift(2'(k), amts[a], regs[2], 1'b1));
            end
        end
    endtask

    task automatic t_imm_zero;
        for (int k = 0; k < 4; k++) begin
            issue("R4 imm zero c0", 4'd1, 4'd0, 1'b0, 2'(k), 5'd0, 1'b0,
                  ref_imm(2'(k), 0, regs[1], 1'b0));
            issue("R4 imm zero c1", 4'd2, 4'd0, 1'b0, 2'(k), 5'd0, 1'b1,
                  ref_imm(2'(k), 0, regs[2], 1'b1));
        end
    endtask

    task automatic t_reg_zero;
        // regs[4] = 0x100: low byte 0, bit 8 set must be ignored
        for (int k = 0; k < 4; k++)
            issue("R5 reg count zero", 4'd1, 4'd4, 1'b1, 2'(k), 5'd3, 1'b1, {1'b1, regs[1]});
        // regs[3] = 0xABCD0104: count 4 from low byte
        issue("R5 reg count low byte", 4'd2, 4'd3, 1'b1, 2'b01, 5'd9, 1'b0,
              ref_shift(2'b01, 4, regs[2], 1'b0));
    endtask

    task automatic t_reg_large;
        int cnts [5] = '{32, 33, 40, 64, 100};
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 5; a++) begin
                regs[5] = 32'(cnts[a]);
                issue("R6 reg count large", 4'd6, 4'd5, 1'b1, 2'(k), 5'd1, 1'b0,
                      ref_shift(2'(k), cnts[a], regs[6], 1'b0));
            end
        end
        regs[5] = 32'd36;
        issue("R6 rotate modulo", 4'd2, 4'd5, 1'b1, 2'b11, 5'd1, 1'b0,
              ref_shift(2'b11, 4, regs[2], 1'b0));
    endtask

    task automatic t_pc_operand;
        pc_word = 24'h12_3456; psr_nzcv = 4'b1010; psr_masks = 2'b01; psr_mode = 2'b10;
        issue("R7 pc operand imm", 4'd15, 4'd0, 1'b0, 2'b00, 5'd0, 1'b0,
              {1'b0, 4'b1010, 2'b01, 24'h12_3458, 2'b10});
        issue("R7 pc operand reg", 4'd15, 4'd4, 1'b1, 2'b00, 5'd0, 1'b1,
              {1'b1, 4'b1010, 2'b01, 24'h12_3459, 2'b10});
    endtask

    task automatic t_pc_count;
        // PC word 4 -> +8 bytes gives word 6, count byte 24; mode 11 must not leak
        pc_word = 24'h00_0004; psr_mode = 2'b11;
        issue("R8 pc count", 4'd7, 4'd15, 1'b1, 2'b01, 5'd2, 1'b0,
              ref_shift(2'b01, 24, regs[7], 1'b0));
    endtask

    task automatic t_disabled;
        reg_shift_en = 1'b0;
        issue("R9 flag ignored", 4'd1, 4'd4, 1'b1, 2'b00, 5'd4, 1'b0,
              ref_shift(2'b00, 4, regs[1], 1'b0));
        pc_word = 24'h00_0100; psr_nzcv = 4'b0001; psr_masks = 2'b10; psr_mode = 2'b00;
        issue("R9 pc near", 4'd15, 4'd4, 1'b1, 2'b00, 5'd0, 1'b0,
              {1'b0, 4'b0001, 2'b10, 24'h00_0102, 2'b00});
        reg_shift_en = 1'b1;
    endtask

    task automatic t_hold;
        logic [31:0] last_v;
        logic        last_c;
        issue("R2 result", 4'd2, 4'd0, 1'b0, 2'b01, 5'd3, 1'b0,
              ref_shift(2'b01, 3, regs[2], 1'b0));
        last_v = out_value; last_c = out_carry;
        rm_idx = 4'd1; shift_imm = 5'd7;
        @(negedge clk);
        @(negedge clk);
        check("R2 idle valid", 32'(out_valid), 32'd0);
        check("R2 idle value hold", out_value, last_v);
        check("R2 idle carry hold", 32'(out_carry), 32'(last_c));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0101_0101 * 32'(i);
        regs[1]  = 32'hB3C5_7E19;
        regs[2]  = 32'h4A6F_0D82;
        regs[3]  = 32'hABCD_0104;
        regs[4]  = 32'h0000_0100;
        regs[6]  = 32'h8000_0001;
        regs[7]  = 32'hF080_0000;
        regs[15] = 32'hDEAD_BEEF;
        t_reset();
        t_addresses();
        t_imm_shifts();
        t_imm_zero();
        t_reg_zero();
        t_reg_large();
        t_pc_operand();
        t_pc_count();
        t_disabled();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule